// File: doc/BRIEF.md
# Fixed Off-Time PWM Chopper

This block drives the four switches of one H-bridge phase of a stepper winding. Each chopping cycle starts with an on-period. In that period the diagonal switch pair selected by the phase polarity conducts, and current rises in the winding. The block ignores the current-trip comparator for a short blanking window after the on-period begins, so switching transients cannot end the on-period early. When the comparator reports that the current has reached its target, the on-period ends and a fixed off-time begins.

During the off-time the winding current decays in one of two ways, chosen by the decay request. Slow decay runs for the whole off-time. Mixed decay runs fast decay for the first 5/16 of the off-time and slow decay for the rest. Fast decay drives the opposite diagonal. Slow decay closes both low-side switches, which gives synchronous rectification. While the zero-current indication is high, all rectifying switches open so the current cannot reverse.

A per-leg dead-time stage sits between the pattern logic and the gates. It keeps both switches of a leg open for a set number of clocks whenever that leg's wanted state changes. The drive-off input forces every gate open. The comparator, the reference and the gate supply are outside this block.

Top module: `fixed_off_chopper`

## Requirements
- R1: While `rst_n` is low all four gates are 0. After reset the block starts in an on-period.
- R2: In an on-period with `phase_pol`=1 the wanted state is leg A high and leg B low. With `phase_pol`=0 it is leg B high and leg A low.
- R3: `trip` is ignored during the first BLANK_CYC clock cycles of every on-period, counted from the first cycle of that on-period.
- R4: An accepted trip starts an off-time on the next cycle. The off-time lasts N cycles, where N is `off_cycles` sampled at the trip, and a value of 0 acts as 1. A new on-period follows at once.
- R5: `decay_mixed` is sampled at the trip. When it is 1, the first floor(5*N/16) off-time cycles want fast decay: leg A low and leg B high for `phase_pol`=1, the mirror for 0. The remaining cycles want slow decay, which is both legs low. When it is 0, the whole off-time wants slow decay.
- R6: While `near_zero` is 1 during an off-time, both legs want all switches open. The off-time count keeps running.
- R7: While `drv_off` is 1, both legs want all switches open and the chopper is held at the start of an on-period. Gates are all 0 from the cycle after `drv_off` is seen high.
- R8: Gates follow the wanted state one clock later. When a leg's wanted state changes, both of its gates stay 0 for DEAD_CYC cycles before the new state is applied.
- R9: The high and low gates of a leg are never both 1. A high gate is 1 only while the low gate of the other leg is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| phase_pol | input | 1 | Current direction: 1 = leg A to leg B |
| decay_mixed | input | 1 | Decay request: 1 = mixed, 0 = slow |
| trip | input | 1 | Current-trip comparator output |
| drv_off | input | 1 | 1 forces all gates open |
| near_zero | input | 1 | Winding current is close to zero |
| off_cycles | input | OFF_W | Off-time length in clock cycles |
| gate_ah | output | 1 | Leg A high-side gate |
| gate_al | output | 1 | Leg A low-side gate |
| gate_bh | output | 1 | Leg B high-side gate |
| gate_bl | output | 1 | Leg B low-side gate |

## Verification
The hardest situations to reach are when the zero-current indication toggles inside the fast part of a mixed off-time, or when a trip is held across the exact cycle where blanking ends. In the first case the two legs' dead-time windows overlap with the change from fast to slow decay. The bench holds `trip` high from the start of an on-period so acceptance lands on the first unblanked cycle. It then pulses `near_zero` at several offsets inside a long mixed off-time. A behavioural model predicts every gate on every clock.

// File: rtl/fixed_off_chopper_pkg.sv
// Package: shared encodings for the fixed off-time chopper.
// Assumes: a leg request never asks for both switches at once.
package fixed_off_chopper_pkg;
    // Wanted state of one bridge leg: bit 1 = high switch, bit 0 = low switch
    localparam logic [1:0] LEG_OPEN = 2'b00;
    localparam logic [1:0] LEG_LOW  = 2'b01;
    localparam logic [1:0] LEG_HIGH = 2'b10;

    typedef enum logic {
        PH_ON  = 1'b0,
        PH_OFF = 1'b1
    } chop_phase_e;
endpackage

// File: rtl/chop_seq.sv
// Module: chop_seq
// Sequences on-periods and fixed off-times. It counts blanking cycles at the
// start of each on-period, samples the off-time length and the decay request
// when a trip is accepted, and flags the fast-decay part of a mixed off-time.
// Assumes: BLANK_CYC >= 1; trip is already synchronous to clk.
module chop_seq
    import fixed_off_chopper_pkg::*;
#(
    parameter int OFF_W     = 16,
    parameter int BLANK_CYC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic             trip,
    input  logic             mixed_in,
    input  logic [OFF_W-1:0] off_in,
    output logic             in_off,
    output logic             is_fast
);
    localparam int BW = $clog2(BLANK_CYC + 1);
    localparam int FW = OFF_W + 3;

    chop_phase_e      phase_q;
    logic [BW-1:0]    blank_q;
    logic [OFF_W-1:0] oc_q;
    logic [OFF_W-1:0] len_q;
    logic             mix_q;

    logic             blank_done;
    logic             off_last;
    logic [FW-1:0]    prod;
    logic [OFF_W-1:0] fast_n;

    // Derive blanking status, end of off-time and the fast-decay boundary
    always_comb begin
        blank_done = (blank_q >= BW'(BLANK_CYC));
        off_last   = (({1'b0, oc_q} + {{OFF_W{1'b0}}, 1'b1}) >= {1'b0, len_q});
        prod       = {3'b000, len_q} * FW'(5);
        fast_n     = {1'b0, prod[FW-1:4]};
        in_off     = (phase_q == PH_OFF);
        is_fast    = in_off && mix_q && (oc_q < fast_n);
    end

    // Advance the on/off phase and its counters
    always_ff @(posedge clk) begin
        if (!rst_n || hold) begin
            phase_q <= PH_ON;
            blank_q <= '0;
            oc_q    <= '0;
            len_q   <= '0;
            mix_q   <= 1'b0;
        end else if (phase_q == PH_ON) begin
            if (trip && blank_done) begin
                phase_q <= PH_OFF;
                oc_q    <= '0;
                len_q   <= off_in;
                mix_q   <= mixed_in;
            end else if (!blank_done) begin
                blank_q <= blank_q + BW'(1);
            end
        end else begin
            if (off_last) begin
                phase_q <= PH_ON;
                blank_q <= '0;
            end else begin
                oc_q <= oc_q + OFF_W'(1);
            end
        end
    end
endmodule

// File: rtl/chop_pattern.sv
// Module: chop_pattern
// Maps the chopper phase, polarity and decay part to a wanted state for each
// leg. Purely combinational.
// Assumes: is_fast is only high while in_off is high.
module chop_pattern
    import fixed_off_chopper_pkg::*;
(
    input  logic       pol,
    input  logic       in_off,
    input  logic       is_fast,
    input  logic       near_zero,
    input  logic       drv_off,
    output logic [1:0] want_a,
    output logic [1:0] want_b
);
    // Select drive, fast decay, slow decay or open for both legs
    always_comb begin
        if (drv_off) begin
            want_a = LEG_OPEN;
            want_b = LEG_OPEN;
        end else if (!in_off) begin
            want_a = pol ? LEG_HIGH : LEG_LOW;
            want_b = pol ? LEG_LOW  : LEG_HIGH;
        end else if (near_zero) begin
            want_a = LEG_OPEN;
            want_b = LEG_OPEN;
        end else if (is_fast) begin
            want_a = pol ? LEG_LOW  : LEG_HIGH;
            want_b = pol ? LEG_HIGH : LEG_LOW;
        end else begin
            want_a = LEG_LOW;
            want_b = LEG_LOW;
        end
    end
endmodule

// File: rtl/chop_deadband.sv
// Module: chop_deadband
// Registers one leg's wanted state and holds both gates open for DEAD_CYC
// cycles after every change of that state.
// Assumes: the wanted state never has both bits set; DEAD_CYC >= 1.
module chop_deadband
    import fixed_off_chopper_pkg::*;
#(
    parameter int DEAD_CYC = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] want,
    output logic       hi,
    output logic       lo
);
    localparam int DW = $clog2(DEAD_CYC + 1);

    logic [1:0]    cur_q;
    logic [DW-1:0] dt_q;

    // Capture a new wanted state and restart the dead-time count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= LEG_OPEN;
            dt_q  <= '0;
        end else if (want != cur_q) begin
            cur_q <= want;
            dt_q  <= DW'(DEAD_CYC);
        end else if (dt_q != '0) begin
            dt_q <= dt_q - DW'(1);
        end
    end

    // Drive the gates only once the dead-time has run out
    always_comb begin
        hi = (dt_q == '0) && cur_q[1];
        lo = (dt_q == '0) && cur_q[0];
    end
endmodule

// File: rtl/fixed_off_chopper.sv
// Module: fixed_off_chopper (top)
// Fixed off-time PWM chopper for one H-bridge phase: blanking, trip-started
// off-time, mixed or slow decay, zero-current rectifier cut-off, dead-time.
// Assumes: all inputs synchronous to clk; BLANK_CYC > DEAD_CYC so blanking
// covers the gate turn-on delay.
module fixed_off_chopper
    import fixed_off_chopper_pkg::*;
#(
    parameter int OFF_W     = 16,
    parameter int BLANK_CYC = 4,
    parameter int DEAD_CYC  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             phase_pol,
    input  logic             decay_mixed,
    input  logic             trip,
    input  logic             drv_off,
    input  logic             near_zero,
    input  logic [OFF_W-1:0] off_cycles,
    output logic             gate_ah,
    output logic             gate_al,
    output logic             gate_bh,
    output logic             gate_bl
);
    localparam int NLEG = 2;

    logic       in_off;
    logic       is_fast;
    logic [1:0] want [NLEG];
    logic       hi   [NLEG];
    logic       lo   [NLEG];

    chop_seq #(
        .OFF_W     (OFF_W),
        .BLANK_CYC (BLANK_CYC)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold     (drv_off),
        .trip     (trip),
        .mixed_in (decay_mixed),
        .off_in   (off_cycles),
        .in_off   (in_off),
        .is_fast  (is_fast)
    );

    chop_pattern u_pat (
        .pol       (phase_pol),
        .in_off    (in_off),
        .is_fast   (is_fast),
        .near_zero (near_zero),
        .drv_off   (drv_off),
        .want_a    (want[0]),
        .want_b    (want[1])
    );

    for (genvar g = 0; g < NLEG; g++) begin : g_leg
        chop_deadband #(
            .DEAD_CYC (DEAD_CYC)
        ) u_db (
            .clk   (clk),
            .rst_n (rst_n),
            .want  (want[g]),
            .hi    (hi[g]),
            .lo    (lo[g])
        );
    end

    // Route leg outputs to named gate ports
    always_comb begin
        gate_ah = hi[0];
        gate_al = lo[0];
        gate_bh = hi[1];
        gate_bl = lo[1];
    end
endmodule

// File: rtl/fixed_off_chopper_chk.sv
// Module: fixed_off_chopper_chk
// Property checker bound to fixed_off_chopper; watches ports only.
module fixed_off_chopper_chk (
    input logic clk,
    input logic rst_n,
    input logic drv_off,
    input logic gate_ah,
    input logic gate_al,
    input logic gate_bh,
    input logic gate_bl
);
    a_r9_no_shoot: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_ah && gate_al) && !(gate_bh && gate_bl));

    a_r9_diag_a: assert property (@(posedge clk) disable iff (!rst_n)
        gate_ah |-> gate_bl);

    a_r9_diag_b: assert property (@(posedge clk) disable iff (!rst_n)
        gate_bh |-> gate_al);

    a_r7_forced_open: assert property (@(posedge clk) disable iff (!rst_n)
        $past(drv_off) |-> !(gate_ah || gate_al || gate_bh || gate_bl));

    a_r8_dead_ah: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_ah) |-> !$past(gate_al));

    a_r8_dead_al: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_al) |-> !$past(gate_ah));

    a_r8_dead_bh: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_bh) |-> !$past(gate_bl));

    a_r8_dead_bl: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_bl) |-> !$past(gate_bh));
endmodule

bind fixed_off_chopper fixed_off_chopper_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .drv_off (drv_off),
    .gate_ah (gate_ah),
    .gate_al (gate_al),
    .gate_bh (gate_bh),
    .gate_bl (gate_bl)
);

// File: tb/fixed_off_chopper_test.sv
module fixed_off_chopper_test;
    localparam int CLK_PERIOD = 10;
    localparam int BLANK = 4;
    localparam int DEAD  = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        phase_pol = 1'b1;
    logic        decay_mixed = 1'b0;
    logic        trip = 1'b0;
    logic        drv_off = 1'b0;
    logic        near_zero = 1'b0;
    logic [15:0] off_cycles = 16'd16;
    logic        gate_ah, gate_al, gate_bh, gate_bl;

    int    n_vec = 0;
    int    n_bad = 0;
    int    cyc = 0;
    bit    done = 0;
    string tag = "R1";

    // behavioural reference state
    int m_off = 0;      // 1 while in off-time
    int m_blank = 0;    // cycles spent in current on-period (saturating)
    int m_oc = 0;       // cycles spent in current off-time
    int m_len = 1;
    int m_mix = 0;
    int m_cur[2] = '{0, 0};  // 0 open, 1 low, 2 high
    int m_dt[2]  = '{0, 0};

    fixed_off_chopper #(.OFF_W(16), .BLANK_CYC(BLANK), .DEAD_CYC(DEAD)) uut (
        .clk(clk), .rst_n(rst_n), .phase_pol(phase_pol), .decay_mixed(decay_mixed),
        .trip(trip), .drv_off(drv_off), .near_zero(near_zero), .off_cycles(off_cycles),
        .gate_ah(gate_ah), .gate_al(gate_al), .gate_bh(gate_bh), .gate_bl(gate_bl));

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int want_leg(int leg);
        int fast_n;
        fast_n = (m_len * 5) / 16;
        if (drv_off) return 0;
        if (m_off == 0) return ((leg == 0) == phase_pol) ? 2 : 1;
        if (near_zero) return 0;
        if (m_mix != 0 && m_oc < fast_n) return ((leg == 0) == phase_pol) ? 1 : 2;
        return 1;
    endfunction

    // reference update on every rising edge
    always @(posedge clk) begin
        int w[2];
        w[0] = want_leg(0);
        w[1] = want_leg(1);
        if (!rst_n) begin
            m_off = 0; m_blank = 0; m_oc = 0; m_len = 1; m_mix = 0;
            for (int i = 0; i < 2; i++) begin m_cur[i] = 0; m_dt[i] = 0; end
        end else begin
            for (int i = 0; i < 2; i++) begin
                if (w[i] != m_cur[i]) begin m_cur[i] = w[i]; m_dt[i] = DEAD; end
                else if (m_dt[i] > 0) m_dt[i] = m_dt[i] - 1;
            end
            if (drv_off) begin
                m_off = 0; m_blank = 0;
            end else if (m_off == 0) begin
                if (trip && m_blank >= BLANK) begin
                    m_off = 1; m_oc = 0; m_mix = decay_mixed;
                    m_len = (off_cycles == 0) ? 1 : int'(off_cycles);
                end else if (m_blank < BLANK) m_blank++;
            end else begin
                if (m_oc + 1 >= m_len) begin m_off = 0; m_blank = 0; end
                else m_oc++;
            end
        end
    end

    function automatic logic [3:0] model_gates();
        logic [3:0] g;
        g[3] = (m_dt[0] == 0) && (m_cur[0] == 2);
        g[2] = (m_dt[0] == 0) && (m_cur[0] == 1);
        g[1] = (m_dt[1] == 0) && (m_cur[1] == 2);
        g[0] = (m_dt[1] == 0) && (m_cur[1] == 1);
        return g;
    endfunction

    // compare against the model away from the active edge
    always @(negedge clk) begin
        logic [3:0] act, exp_g;
        cyc++;
        act = {gate_ah, gate_al, gate_bh, gate_bl};
        exp_g = model_gates();
        if (rst_n) begin
            n_vec++;
            if (act !== exp_g) begin
                n_bad++;
                $display("FAIL %s cycle %0d: gates=%b expected %b", tag, cyc, act, exp_g);
            end
            n_vec++;  // R9: leg exclusivity and diagonal pairing
            if ((gate_ah && gate_al) || (gate_bh && gate_bl) ||
                (gate_ah && !gate_bl) || (gate_bh && !gate_al)) begin
                n_bad++;
                $display("FAIL R9 cycle %0d: gates=%b expected no shoot-through", cyc, act);
            end
        end
        if (cyc > 20000 && !done) begin
            n_bad++;
            $display("FAIL watchdog: cycles=%0d expected finish before 20000", cyc);
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    task automatic run(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_reset_zero();
        n_vec++;
        if ({gate_ah, gate_al, gate_bh, gate_bl} !== 4'b0000) begin
            n_bad++;
            $display("FAIL R1: gates=%b expected 0000",
                     {gate_ah, gate_al, gate_bh, gate_bl});
        end
    endtask

    initial begin
        run(3);
        tag = "R1"; check_reset_zero();
        rst_n = 1'b1;
        run(10);                           // R1/R2: on-period drive after reset
        tag = "R2"; phase_pol = 1'b0; run(10);
        tag = "R8"; phase_pol = 1'b1; run(1); phase_pol = 1'b0; run(8);
        // R3: trip held from the start of a fresh on-period
        tag = "R3"; drv_off = 1'b1; run(2); drv_off = 1'b0;
        off_cycles = 16'd32; decay_mixed = 1'b1; trip = 1'b1; run(BLANK + 1);
        trip = 1'b0;
        tag = "R5"; run(40);               // 10 fast, 22 slow
        tag = "R4"; decay_mixed = 1'b0; off_cycles = 16'd7;
        for (int k = 0; k < 4; k++) begin trip = 1'b1; run(1); trip = 1'b0; run(12); end
        off_cycles = 16'd0; trip = 1'b1; run(20); trip = 1'b0; run(6);
        tag = "R5"; phase_pol = 1'b1; decay_mixed = 1'b1; off_cycles = 16'd17;
        trip = 1'b1; run(BLANK + 2); trip = 1'b0; run(25);
        tag = "R6"; off_cycles = 16'd48; trip = 1'b1; run(BLANK + 2); trip = 1'b0;
        for (int k = 0; k < 5; k++) begin
            run(2 + k); near_zero = 1'b1; run(3); near_zero = 1'b0;
        end
        run(30);
        tag = "R7"; trip = 1'b1; run(BLANK + 3); trip = 1'b0; run(4);
        drv_off = 1'b1; run(6); drv_off = 1'b0; run(15);
        tag = "R1"; @(negedge clk) rst_n = 1'b0; run(2); check_reset_zero();
        rst_n = 1'b1; run(10);
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule